// File: doc/BRIEF.md
# Self-Clocked Serial Result Transmitter

This block moves one 16-bit conversion result at a time off the chip over a serial link whose clock it drives itself. A free-running timebase divides time into sampling intervals of 1024 master clocks, made of 16 periods of 64 clocks each. Settling periods and computation periods alternate, and the interval opens with a settling period. Transmission is allowed only inside computation periods. At the clock edge that opens each computation period the block looks at the active-low chip select. If chip select is low and a result is waiting, the block drives its serial clock and data pins and shifts the word out, most significant bit first.

A host can pause a word partway through by raising chip select. The block stops once the bit in flight is finished and releases both pins. The word carries on from the next unsent bit in a later computation period once chip select is low again. A ready flag, active low, tells the host that a result is waiting. Loading a new result replaces the held word, abandons any transfer in progress, and marks the change by holding the ready flag high for four clocks.

Top module: `ssc_serial_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `drdy_o` is 1, `sclk_oe_o` and `sdata_oe_o` are 0, `sclk_o` is 1 and `sdata_o` is 0. The timebase count is 0 during reset, so the first cycle after reset is offset 0 of period 0.
- R2: The timebase position is the cycle count since reset, modulo 1024. Period = position / 64, offset = position mod 64. Even periods are settling and odd periods are computation. `cs_n_i` is sampled at the clock edge that ends offset 63 of a settling period. If it is low and `drdy_o` is 0, both output enables go high at offset 0 of the following computation period. In every other case no transfer starts.
- R3: Bits leave most significant first. `sclk_o` runs at one quarter of the clock rate: two cycles low, then two cycles high. Rising edges within a run are exactly 4 cycles apart.
- R4: `sdata_o` changes only in the cycle in which `sclk_o` falls. It holds steady across both high cycles of `sclk_o`.
- R5: The cycle after the second high cycle of the least significant bit, `drdy_o` is 1 and both output enables are 0.
- R6: `cs_n_i` is sampled at the closing edge of every bit. If it is high there, the transfer stops after that bit, both enables drop and `drdy_o` stays 0.
- R7: A paused word continues with its next unsent bit at the start of a later computation period whose opening sample of `cs_n_i` is low. No bit is repeated and none is skipped.
- R8: A cycle with `load_i` high stores `data_i`, resets the bit pointer to the MSB and ends any transfer in progress. `drdy_o` is then 1 for exactly the next four cycles and 0 in the fifth. No transfer starts while it is held high.
- R9: The output enables are high only during computation periods.
- R10: When no word is waiting (`drdy_o` high), a low `cs_n_i` at the opening sample starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | One-cycle strobe: a new result is on `data_i` |
| data_i | input | 16 | Result word to be sent |
| cs_n_i | input | 1 | Chip select from the host, active low |
| sclk_o | output | 1 | Generated serial clock, idles high |
| sclk_oe_o | output | 1 | Drive enable for the serial clock pin |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Drive enable for the serial data pin |
| drdy_o | output | 1 | Low while an unsent or partly sent word is held |

## Verification
Each result has its own latency. `drdy_o` rises in the cycle after a load and falls five cycles after it. The enables rise in the cycle after the opening sample of chip select, and the first serial clock rise comes two cycles later. A pause lands after the bit in flight, because chip select is only looked at on each bit's closing edge. Completion shows one cycle after the last high cycle. The bench drives inputs just after the falling clock edge and samples every output on the falling edge. It keeps its own copy of the interval position, derived from the cycle count since reset, and uses it to judge where each start, each rising serial clock edge and each data change should fall.

// File: rtl/ssc_pkg.sv
// Package: shared types for the self-clocked serial transmitter.
// Assumes nothing beyond the standard language.
package ssc_pkg;

    // Link state of the bit shifter.
    typedef enum logic {
        LINK_IDLE = 1'b0,
        LINK_SEND = 1'b1
    } link_state_e;

endpackage : ssc_pkg

// File: rtl/ssc_timebase.sv
// Module: ssc_timebase
// Counts master clocks through one sampling interval of NUM_PERIODS periods of
// PERIOD_CLKS clocks each. Even periods are settling, odd periods computation.
// Assumes PERIOD_CLKS and NUM_PERIODS are powers of two (the count wraps
// naturally) and NUM_PERIODS is even.
module ssc_timebase #(
    parameter int PERIOD_CLKS = 64,
    parameter int NUM_PERIODS = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic poll_o,      // last cycle of a settling period
    output logic win_last_o,  // last cycle of a computation period
    output logic compute_o    // current period is a computation period
);
    localparam int OFF_W = $clog2(PERIOD_CLKS);
    localparam int PER_W = $clog2(NUM_PERIODS);
    localparam int CNT_W = OFF_W + PER_W;
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(PERIOD_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last_off;

    // Free-running interval position, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Period parity and end-of-period decode.
    always_comb begin
        at_last_off = (cnt_q[OFF_W-1:0] == OFF_LAST);
        compute_o   = cnt_q[OFF_W];
        poll_o      = !cnt_q[OFF_W] && at_last_off;
        win_last_o  =  cnt_q[OFF_W] && at_last_off;
    end

endmodule : ssc_timebase

// File: rtl/ssc_word_hold.sv
// Module: ssc_word_hold
// Holds the output word and the pointer to the next bit to send. Also owns
// the ready flag and the short blanking pulse raised when a word is replaced.
// Assumes step_i is asserted for one cycle on the closing edge of each bit.
module ssc_word_hold #(
    parameter int WORD_W     = 16,
    parameter int BLANK_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              step_i,
    output logic              bit_o,    // bit under the pointer
    output logic              last_o,   // pointer is at the LSB
    output logic              ready_o,  // a word may start or resume
    output logic              drdy_o
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam int BL_W  = $clog2(BLANK_CLKS + 1);
    localparam logic [IDX_W-1:0] MSB_IDX   = IDX_W'(WORD_W - 1);
    localparam logic [BL_W-1:0]  BLANK_SET = BL_W'(BLANK_CLKS);

    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pending_q;
    logic [BL_W-1:0]   blank_q;

    // Word storage, bit pointer, pending flag and blanking counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            idx_q     <= MSB_IDX;
            pending_q <= 1'b0;
            blank_q   <= '0;
        end else if (load_i) begin
            word_q    <= data_i;
            idx_q     <= MSB_IDX;
            pending_q <= 1'b1;
            blank_q   <= BLANK_SET;
        end else begin
            if (blank_q != '0) begin
                blank_q <= blank_q - 1'b1;
            end
            if (step_i) begin
                if (idx_q == '0) begin
                    pending_q <= 1'b0;
                end else begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end

    // Bit select and flag decode.
    always_comb begin
        bit_o   = word_q[idx_q];
        last_o  = (idx_q == '0);
        ready_o = pending_q && (blank_q == '0);
        drdy_o  = !pending_q || (blank_q != '0);
    end

endmodule : ssc_word_hold

// File: rtl/ssc_shifter.sv
// Module: ssc_shifter
// Runs the serial clock while a word is being sent. It starts on a window
// poll and stops after a bit when the word is done, when chip select is
// high, or at the end of the window.
// Assumes WORD bits x SCLK_DIV clocks fit in one computation period.
module ssc_shifter #(
    parameter int SCLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic poll_i,
    input  logic win_last_i,
    input  logic cs_n_i,
    input  logic ready_i,
    input  logic last_i,
    input  logic abort_i,
    output logic active_o,
    output logic sclk_o,
    output logic step_o
);
    import ssc_pkg::*;

    localparam int PH_W = $clog2(SCLK_DIV);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SCLK_DIV - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(SCLK_DIV / 2);

    link_state_e     state_q;
    logic [PH_W-1:0] phase_q;

    // Start, bit phase advance and stop decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_IDLE;
            phase_q <= '0;
        end else if (abort_i) begin
            state_q <= LINK_IDLE;
            phase_q <= '0;
        end else begin
            case (state_q)
                LINK_IDLE: begin
                    phase_q <= '0;
                    if (poll_i && ready_i && !cs_n_i) begin
                        state_q <= LINK_SEND;
                    end
                end
                LINK_SEND: begin
                    if (phase_q == PH_LAST) begin
                        phase_q <= '0;
                        if (last_i || cs_n_i || win_last_i) begin
                            state_q <= LINK_IDLE;
                        end
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                default: state_q <= LINK_IDLE;
            endcase
        end
    end

    // Serial clock level and bit-close strobe.
    always_comb begin
        active_o = (state_q == LINK_SEND);
        sclk_o   = active_o ? (phase_q >= PH_HIGH) : 1'b1;
        step_o   = active_o && (phase_q == PH_LAST);
    end

endmodule : ssc_shifter

// File: rtl/ssc_serial_tx.sv
// Module: ssc_serial_tx (top)
// Self-clocked serial transmitter. A word loaded with load_i is sent MSB first
// during computation periods while cs_n_i is low, and may pause and resume
// bit by bit. Assumes a single clock domain; cs_n_i is already synchronous.
module ssc_serial_tx #(
    parameter int WORD_W      = 16,
    parameter int PERIOD_CLKS = 64,
    parameter int NUM_PERIODS = 16,
    parameter int SCLK_DIV    = 4,
    parameter int BLANK_CLKS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              cs_n_i,
    output logic              sclk_o,
    output logic              sclk_oe_o,
    output logic              sdata_o,
    output logic              sdata_oe_o,
    output logic              drdy_o
);
    logic poll_w;
    logic win_last_w;
    logic compute_w;
    logic step_w;
    logic bit_w;
    logic last_w;
    logic ready_w;
    logic active_w;
    logic sclk_w;

    ssc_timebase #(
        .PERIOD_CLKS (PERIOD_CLKS),
        .NUM_PERIODS (NUM_PERIODS)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .poll_o     (poll_w),
        .win_last_o (win_last_w),
        .compute_o  (compute_w)
    );

    ssc_word_hold #(
        .WORD_W     (WORD_W),
        .BLANK_CLKS (BLANK_CLKS)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .data_i  (data_i),
        .step_i  (step_w),
        .bit_o   (bit_w),
        .last_o  (last_w),
        .ready_o (ready_w),
        .drdy_o  (drdy_o)
    );

    ssc_shifter #(
        .SCLK_DIV (SCLK_DIV)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .poll_i     (poll_w),
        .win_last_i (win_last_w),
        .cs_n_i     (cs_n_i),
        .ready_i    (ready_w),
        .last_i     (last_w),
        .abort_i    (load_i),
        .active_o   (active_w),
        .sclk_o     (sclk_w),
        .step_o     (step_w)
    );

    // Pin drive: both pins share the shifter's activity.
    always_comb begin
        sclk_o     = sclk_w;
        sclk_oe_o  = active_w;
        sdata_oe_o = active_w;
        sdata_o    = active_w ? bit_w : 1'b0;
    end

endmodule : ssc_serial_tx

// File: rtl/ssc_serial_tx_chk.sv
// Module: ssc_serial_tx_chk
// Property checker for ssc_serial_tx, attached with bind. It only observes.
// Assumes reset is synchronous and active low.
module ssc_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic load_i,
    input logic cs_n_i,
    input logic sclk_o,
    input logic sclk_oe_o,
    input logic sdata_o,
    input logic sdata_oe_o,
    input logic drdy_o,
    input logic in_compute
);
    AST_SEND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_oe_o |-> in_compute);  // R9

    AST_START_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe_o) |-> (!drdy_o && !$past(cs_n_i)));  // R2

    AST_LOAD_RAISES_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (drdy_o && !sdata_oe_o));  // R8

    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe_o && $past(sdata_oe_o) && sclk_o && $past(sclk_o)) |-> $stable(sdata_o));  // R4

    AST_DONE_RAISES_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sdata_oe_o) && !$past(load_i) && !$past(cs_n_i)) |-> drdy_o);  // R5

endmodule : ssc_serial_tx_chk

bind ssc_serial_tx ssc_serial_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .cs_n_i     (cs_n_i),
    .sclk_o     (sclk_o),
    .sclk_oe_o  (sclk_oe_o),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o),
    .drdy_o     (drdy_o),
    .in_compute (compute_w)
);

// File: tb/tb_ssc_serial_tx.sv
// Bench for ssc_serial_tx: directed corner cases plus seeded random words
// with random pause points. Inputs change just after the falling clock edge,
// and outputs are sampled on the falling edge.
module tb_ssc_serial_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] data_i = '0;
    logic        cs_n_i = 1'b1;
    logic        sclk_o, sclk_oe_o, sdata_o, sdata_oe_o, drdy_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ssc_serial_tx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .data_i     (data_i),
        .cs_n_i     (cs_n_i),
        .sclk_o     (sclk_o),
        .sclk_oe_o  (sclk_oe_o),
        .sdata_o    (sdata_o),
        .sdata_oe_o (sdata_oe_o),
        .drdy_o     (drdy_o)
    );

    // Bench copy of the interval position (R2): 0 in reset, +1 per clock.
    logic [31:0] tcnt = '0;
    always @(posedge clk) begin
        if (!rst_n) tcnt <= '0;
        else        tcnt <= tcnt + 1;
    end

    // Port-level receiver and timing monitors.
    logic [63:0] rx_hist = '0;
    int rx_cnt = 0, starts = 0, start_bad = 0, win_bad = 0, edge_bad = 0, per_bad = 0;
    logic [31:0] last_rise = '0;
    logic prev_sclk = 1'b1, prev_oe = 1'b0, prev_sdata = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sdata_oe_o && !prev_oe) begin
                starts <= starts + 1;
                if (tcnt[5:0] != 6'd0 || !tcnt[6]) start_bad <= start_bad + 1;
            end
            if (sdata_oe_o && !tcnt[6]) win_bad <= win_bad + 1;
            if (sclk_oe_o && sclk_o && !prev_sclk) begin
                rx_hist <= {rx_hist[62:0], sdata_o};
                rx_cnt  <= rx_cnt + 1;
                if (rx_cnt > 0 && (tcnt - last_rise) < 64 && (tcnt - last_rise) != 4)
                    per_bad <= per_bad + 1;
                last_rise <= tcnt;
            end
            if (sdata_oe_o && prev_oe && sclk_o && prev_sclk && sdata_o != prev_sdata)
                edge_bad <= edge_bad + 1;
        end
        prev_sclk  <= sclk_oe_o ? sclk_o : 1'b1;
        prev_oe    <= sdata_oe_o;
        prev_sdata <= sdata_o;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic load_word(input logic [15:0] w);
        data_i = w;
        load_i = 1'b1;
        step(1);
        load_i = 1'b0;
    endtask

    task automatic wait_bits(input int target, input int max_cyc);
        int n = 0;
        while (rx_cnt < target && n < max_cyc) begin
            step(1);
            n++;
        end
        chk(rx_cnt >= target, "R2 transfer progress timeout", rx_cnt, target);
    endtask

    // Expected first k bits, MSB first, as an integer.
    function automatic logic [15:0] exp_prefix(input logic [15:0] w, input int k);
        return w >> (16 - k);
    endfunction

    function automatic logic [15:0] mask_k(input int k);
        return 16'((32'd1 << k) - 1);
    endfunction

    // Checks the four-cycle DRDY pulse that follows a load (R8).
    task automatic check_pulse();
        for (int i = 0; i < 4; i++) begin
            chk(drdy_o == 1'b1, "R8 drdy high after load", drdy_o, 1);
            step(1);
        end
        chk(drdy_o == 1'b0, "R8 drdy low in fifth cycle", drdy_o, 0);
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        logic [15:0] w;
        int k;
        void'($urandom(32'd20240611));

        // R1: reset state
        step(3);
        chk(drdy_o == 1'b1 && !sdata_oe_o && !sclk_oe_o && sclk_o && !sdata_o,
            "R1 state in reset", {drdy_o, sdata_oe_o, sclk_oe_o, sclk_o, sdata_o}, 5'b10010);
        rst_n = 1'b1;
        step(1);
        chk(drdy_o == 1'b1 && !sdata_oe_o && !sclk_oe_o && sclk_o && !sdata_o,
            "R1 state after reset", {drdy_o, sdata_oe_o, sclk_oe_o, sclk_o, sdata_o}, 5'b10010);

        // R3, R5: directed full word
        cs_n_i = 1'b0;
        base = rx_cnt;
        load_word(16'hA5C3);
        wait_bits(base + 16, 2500);
        chk(rx_hist[15:0] == 16'hA5C3, "R3 word MSB first", rx_hist[15:0], 16'hA5C3);
        step(2);
        chk(drdy_o && !sdata_oe_o && !sclk_oe_o, "R5 done state",
            {drdy_o, sdata_oe_o, sclk_oe_o}, 3'b100);

        // R10: no word waiting, chip select low over a full interval
        base = rx_cnt;
        step(1100);
        chk(rx_cnt == base, "R10 no send without word", rx_cnt, base);
        chk(drdy_o == 1'b1, "R10 drdy stays high", drdy_o, 1);

        // R8: pulses when idle and when replacing a waiting word
        cs_n_i = 1'b1;
        load_word(16'h1234);
        check_pulse();
        load_word(16'hBEEF);
        check_pulse();
        base = rx_cnt;
        cs_n_i = 1'b0;
        wait_bits(base + 16, 2500);
        chk(rx_hist[15:0] == 16'hBEEF, "R8 replaced word sent", rx_hist[15:0], 16'hBEEF);

        // R6, R7: directed pause after five bits
        base = rx_cnt;
        load_word(16'h6E19);
        wait_bits(base + 5, 2500);
        cs_n_i = 1'b1;
        step(1100);
        chk(rx_cnt == base + 5, "R6 pause after bit in flight", rx_cnt, base + 5);
        chk(!drdy_o && !sdata_oe_o, "R6 paused state", {drdy_o, sdata_oe_o}, 2'b00);
        cs_n_i = 1'b0;
        wait_bits(base + 16, 2500);
        chk(rx_hist[15:0] == 16'h6E19, "R7 resumed word", rx_hist[15:0], 16'h6E19);

        // R8: load during a transfer abandons it, new word sent from MSB
        load_word(16'h0F0F);
        base = rx_cnt;
        wait_bits(base + 3, 2500);
        load_word(16'hC00C);
        base = rx_cnt;
        wait_bits(base + 16, 2500);
        chk(rx_hist[15:0] == 16'hC00C, "R8 abort and resend", rx_hist[15:0], 16'hC00C);

        // Random words with random pause points (R3, R5, R6, R7)
        for (int it = 0; it < 6; it++) begin
            w = 16'($urandom);
            k = int'($urandom_range(15, 1));
            base = rx_cnt;
            load_word(w);
            wait_bits(base + k, 2500);
            cs_n_i = 1'b1;
            step(150);
            chk(rx_cnt == base + k, "R6 random pause count", rx_cnt, base + k);
            chk((rx_hist[15:0] & mask_k(k)) == exp_prefix(w, k), "R6 random prefix",
                rx_hist[15:0] & mask_k(k), exp_prefix(w, k));
            cs_n_i = 1'b0;
            wait_bits(base + 16, 2500);
            chk(rx_hist[15:0] == w, "R7 random resumed word", rx_hist[15:0], w);
            step(2);
            chk(drdy_o && !sdata_oe_o, "R5 random done state", {drdy_o, sdata_oe_o}, 2'b10);
        end

        // Timing monitors
        chk(starts > 0 && start_bad == 0, "R2 starts at window offset 0", start_bad, 0);
        chk(win_bad == 0, "R9 drive only in computation periods", win_bad, 0);
        chk(edge_bad == 0, "R4 data stable while sclk high", edge_bad, 0);
        chk(per_bad == 0, "R3 sclk rise spacing", per_bad, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule : tb_ssc_serial_tx